// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounced Make and Break

This block reads a twelve-key switch matrix wired as four row lines and three column lines. It pulls one row line low at a time and watches the active-low column lines. When a column reads low, the scan stops on that row and the closure is timed against a slow tick input. A key that stays closed for the whole wait is reported once: a key code is placed on the code output and a one-cycle valid pulse is raised.

After a report, the block holds its row and waits for every column to read high for a full debounce wait. It then raises a one-cycle release pulse and scans again from the first row. A key held down for any length of time gives one report only. Column lines are asynchronous, so they pass through a flop synchroniser before the block uses them. Each row is driven long enough for the synchronised columns to settle before they are sampled.

The debounce length is a parameter counted in ticks. The tick rate is the timebase, so one setting covers waits from a few milliseconds up to hundreds of milliseconds.

Top module: `keypad_scanner`

## Requirements
- R1: During and after reset, the row outputs drive only row 1 low (row_n_o = 4'b1110), key_valid_o and key_release_o are low, and key_code_o is 0.
- R2: While no key is closed, exactly one row output is low at any time. The low row moves in the order 1, 2, 3, 4, 1, ... and each row stays low for SYNC_STAGES+1 clock cycles.
- R3: A reported key in row r and column c, both counted from 1, has key_code_o = c + 3*r - 3, in the range 1 to 12. Bit k of row_n_o drives row k+1 and bit k of col_n_i reads column k+1.
- R4: A key is reported only if it stays closed without a break for DEBOUNCE_TICKS ticks after it is first detected. A closure shorter than the tick count tick_i gives during that wait produces no report.
- R5: key_valid_o is a one-cycle pulse. While the key stays held, no second pulse follows until a release pulse has been emitted.
- R6: From a report until the release pulse, row_n_o stays on the reported key's row.
- R7: key_release_o pulses for one cycle only after all columns have read high for DEBOUNCE_TICKS ticks in a row. A shorter opening followed by a new closure gives neither a release pulse nor a new report.
- R8: In the cycle of the release pulse the scan has restarted at row 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable that sets the debounce timebase |
| col_n_i | input | 3 | Column lines, active low, asynchronous |
| row_n_o | output | 4 | Row drive, one line low at a time |
| key_code_o | output | 4 | Code of the last reported key |
| key_valid_o | output | 1 | One-cycle pulse when a debounced closure is reported |
| key_release_o | output | 1 | One-cycle pulse when a debounced release is seen |

## Verification
The bench builds the block with its default four-by-three matrix and two synchroniser stages. DEBOUNCE_TICKS is set to 3 and a tick is given every fourth clock, so each debounce wait lasts only about a dozen cycles. This is short enough to press every one of the twelve keys in turn and compare each code with the formula. It is also short enough to check the row sequence over several full scan rounds. Bounces of four cycles on make and on break fall well inside one wait, so they show that a short closure is not reported and a short opening is not taken as a release.

// File: rtl/kp_pkg.sv
package kp_pkg;

    typedef enum logic [1:0] {
        KP_SCAN  = 2'd0,
        KP_MAKE  = 2'd1,
        KP_HELD  = 2'd2,
        KP_BREAK = 2'd3
    } kp_state_e;

endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '1;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/kp_tick_count.sv
module kp_tick_count #(
    parameter int LIMIT = 16,
    parameter int W     = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic done_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        done_o = 1'b0;
        if (clear_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            if (cnt_q == W'(LIMIT - 1)) begin
                done_o = 1'b1;
                cnt_d  = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/kp_col_find.sv
module kp_col_find #(
    parameter int COLS  = 3,
    parameter int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic [COLS-1:0]  col_n_i,
    output logic             hit_o,
    output logic [COL_W-1:0] idx_o
);
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int c = COLS - 1; c >= 0; c--) begin
            if (!col_n_i[c]) begin
                hit_o = 1'b1;
                idx_o = COL_W'(c);
            end
        end
    end
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
    parameter int ROWS           = 4,
    parameter int COLS           = 3,
    parameter int DEBOUNCE_TICKS = 16,
    parameter int SYNC_STAGES    = 2,
    parameter int CODE_W         = $clog2(ROWS * COLS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [COLS-1:0]   col_n_i,
    output logic [ROWS-1:0]   row_n_o,
    output logic [CODE_W-1:0] key_code_o,
    output logic              key_valid_o,
    output logic              key_release_o
);
    import kp_pkg::*;

    localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int COL_W   = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int SETTLE  = SYNC_STAGES + 1;
    localparam int DWELL_W = $clog2(SETTLE + 1);

    typedef struct packed {
        kp_state_e          state;
        logic [ROW_W-1:0]   row;
        logic [COL_W-1:0]   col;
        logic [DWELL_W-1:0] dwell;
        logic [CODE_W-1:0]  code;
        logic               valid;
        logic               release_p;
    } kp_regs_t;

    kp_regs_t r_d, r_q;

    logic [COLS-1:0]  col_s;
    logic             hit;
    logic [COL_W-1:0] hit_idx;
    logic             cnt_clear;
    logic             deb_done;
    logic             all_open;

    kp_sync #(.W(COLS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (col_n_i),
        .q_o   (col_s)
    );

    kp_col_find #(.COLS(COLS), .COL_W(COL_W)) u_find (
        .col_n_i (col_s),
        .hit_o   (hit),
        .idx_o   (hit_idx)
    );

    assign cnt_clear = (r_q.state == KP_SCAN) || (r_q.state == KP_HELD);

    kp_tick_count #(.LIMIT(DEBOUNCE_TICKS)) u_ticks (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cnt_clear),
        .tick_i  (tick_i),
        .done_o  (deb_done)
    );

    assign all_open = &col_s;

    always_comb begin
        r_d           = r_q;
        r_d.valid     = 1'b0;
        r_d.release_p = 1'b0;
        unique case (r_q.state)
            KP_SCAN: begin
                if (r_q.dwell != DWELL_W'(SETTLE - 1)) begin
                    r_d.dwell = r_q.dwell + 1'b1;
                end else if (hit) begin
                    r_d.state = KP_MAKE;
                    r_d.col   = hit_idx;
                end else begin
                    r_d.dwell = '0;
                    r_d.row   = (r_q.row == ROW_W'(ROWS - 1)) ? '0 : r_q.row + 1'b1;
                end
            end
            KP_MAKE: begin
                if (col_s[r_q.col]) begin
                    r_d.state = KP_SCAN;
                    r_d.row   = '0;
                    r_d.dwell = '0;
                end else if (deb_done) begin
                    r_d.state = KP_HELD;
                    r_d.valid = 1'b1;
                    r_d.code  = CODE_W'(int'(r_q.col) + COLS * int'(r_q.row) + 1);
                end
            end
            KP_HELD: begin
                if (all_open) r_d.state = KP_BREAK;
            end
            KP_BREAK: begin
                if (!all_open) begin
                    r_d.state = KP_HELD;
                end else if (deb_done) begin
                    r_d.state     = KP_SCAN;
                    r_d.release_p = 1'b1;
                    r_d.row       = '0;
                    r_d.dwell     = '0;
                end
            end
            default: r_d.state = KP_SCAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= KP_SCAN;
            r_q.row       <= '0;
            r_q.col       <= '0;
            r_q.dwell     <= '0;
            r_q.code      <= '0;
            r_q.valid     <= 1'b0;
            r_q.release_p <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign row_n_o       = ~(ROWS'(1) << r_q.row);
    assign key_code_o    = r_q.code;
    assign key_valid_o   = r_q.valid;
    assign key_release_o = r_q.release_p;
endmodule

// File: rtl/keypad_scanner_chk.sv
module keypad_scanner_chk #(
    parameter int ROWS   = 4,
    parameter int COLS   = 3,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ROWS-1:0]   row_n_o,
    input logic [CODE_W-1:0] key_code_o,
    input logic              key_valid_o,
    input logic              key_release_o
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             armed_q <= 1'b0;
        else if (key_valid_o)   armed_q <= 1'b1;
        else if (key_release_o) armed_q <= 1'b0;
    end

    // R2
    one_row_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~row_n_o) == 1);

    // R3
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid_o |-> (key_code_o >= CODE_W'(1) && key_code_o <= CODE_W'(ROWS * COLS)));

    // R5
    single_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> !key_valid_o);

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid_o |=> !key_valid_o);

    // R6
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |=> ($stable(row_n_o) || key_release_o));

    // R7
    release_after_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_release_o |-> armed_q);

    // R7
    release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_release_o |=> !key_release_o);

    // R8
    restart_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_release_o |-> row_n_o[0] == 1'b0);
endmodule

bind keypad_scanner keypad_scanner_chk #(
    .ROWS   (ROWS),
    .COLS   (COLS),
    .CODE_W (CODE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .row_n_o       (row_n_o),
    .key_code_o    (key_code_o),
    .key_valid_o   (key_valid_o),
    .key_release_o (key_release_o)
);

// File: tb/keypad_scanner_test.sv
module keypad_scanner_test;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS       = 4;
    localparam int COLS       = 3;
    localparam int DEB        = 3;
    localparam int TICK_DIV   = 4;
    localparam int SYNC       = 2;
    localparam int CODE_W     = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [COLS-1:0]   col_n;
    logic [ROWS-1:0]   row_n;
    logic [CODE_W-1:0] key_code;
    logic              key_valid;
    logic              key_release;

    logic pressed = 1'b0;
    int   pr = 0;
    int   pc = 0;

    int total = 0;
    int bad = 0;
    int valid_cnt = 0;
    int rel_cnt = 0;
    int last_code = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign col_n = (pressed && row_n[pr] == 1'b0) ? ~(COLS'(1) << pc) : '1;

    keypad_scanner #(
        .ROWS(ROWS), .COLS(COLS), .DEBOUNCE_TICKS(DEB), .SYNC_STAGES(SYNC), .CODE_W(CODE_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .col_n_i(col_n),
        .row_n_o(row_n), .key_code_o(key_code),
        .key_valid_o(key_valid), .key_release_o(key_release)
    );

    initial begin
        forever begin
            @(negedge clk);
            if (key_valid) begin
                valid_cnt++;
                last_code = int'(key_code);
            end
            if (key_release) rel_cnt++;
        end
    end

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div  = (div == TICK_DIV - 1) ? 0 : div + 1;
            tick = (div == 0);
        end
    end

    task automatic check(input string req, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic wait_valid(input int base, output int cycles);
        cycles = 0;
        while (valid_cnt == base && cycles < 400) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic wait_release(input int base, output int row_at);
        int n = 0;
        row_at = -1;
        while (rel_cnt == base && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (rel_cnt != base) row_at = int'(row_n);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        int cyc;
        int row_at;
        int base_v;
        int base_r;
        int order_err;
        int run_err;
        int run_len;
        int prev_row;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 row_n in reset", int'(row_n), 4'b1110);
        check("R1 valid in reset", int'(key_valid), 0);
        check("R1 release in reset", int'(key_release), 0);
        check("R1 code in reset", int'(key_code), 0);
        rst_n = 1'b1;

        // R2 scan order and dwell with no key
        order_err = 0;
        run_err = 0;
        run_len = 0;
        prev_row = 0;
        for (int i = 0; i < ROWS * (SYNC + 1) * 5; i++) begin
            @(negedge clk);
            if ($countones(~row_n) != 1) order_err++;
            else begin
                int cur = 0;
                for (int k = 0; k < ROWS; k++) if (!row_n[k]) cur = k;
                if (cur == prev_row) run_len++;
                else begin
                    if (cur != (prev_row + 1) % ROWS) order_err++;
                    if (i > SYNC + 1 && run_len != SYNC + 1) run_err++;
                    run_len = 1;
                    prev_row = cur;
                end
            end
        end
        check("R2 row order errors", order_err, 0);
        check("R2 row dwell errors", run_err, 0);

        // R3 R5 R6 R7 R8 sweep over all keys
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                int held_err = 0;
                base_v = valid_cnt;
                base_r = rel_cnt;
                pr = r;
                pc = c;
                pressed = 1'b1;
                wait_valid(base_v, cyc);
                check("R3 key reported", valid_cnt - base_v, 1);
                check("R3 key code", last_code, (c + 1) + 3 * (r + 1) - 3);
                // R4 minimum debounce time from press to report
                check("R4 report not early", int'(cyc >= (DEB - 1) * TICK_DIV), 1);
                for (int k = 0; k < 80; k++) begin
                    @(negedge clk);
                    if (row_n != ~(ROWS'(1) << r)) held_err++;
                end
                check("R5 single report while held", valid_cnt - base_v, 1);
                check("R6 row held on key row", held_err, 0);
                check("R7 no release while held", rel_cnt - base_r, 0);
                pressed = 1'b0;
                wait_release(base_r, row_at);
                check("R7 release pulse", rel_cnt - base_r, 1);
                check("R8 scan restarts at row 1", row_at, 4'b1110);
                check("R5 no report on release", valid_cnt - base_v, 1);
                repeat (20) @(negedge clk);
            end
        end

        // R4 short closure is not reported
        base_v = valid_cnt;
        pr = 2;
        pc = 1;
        for (int b = 0; b < 5; b++) begin
            while (row_n[pr] != 1'b0) @(negedge clk);
            pressed = 1'b1;
            repeat (4) @(negedge clk);
            pressed = 1'b0;
            repeat (30) @(negedge clk);
        end
        check("R4 bounce not reported", valid_cnt - base_v, 0);

        // R7 short opening during hold is not a release
        base_v = valid_cnt;
        base_r = rel_cnt;
        pr = 3;
        pc = 2;
        pressed = 1'b1;
        wait_valid(base_v, cyc);
        check("R3 code row 4 col 3", last_code, 12);
        repeat (10) @(negedge clk);
        for (int b = 0; b < 4; b++) begin
            pressed = 1'b0;
            repeat (4) @(negedge clk);
            pressed = 1'b1;
            repeat (20) @(negedge clk);
        end
        check("R7 brief opening no release", rel_cnt - base_r, 0);
        check("R7 brief opening no new report", valid_cnt - base_v, 1);
        pressed = 1'b0;
        wait_release(base_r, row_at);
        check("R7 release after real opening", rel_cnt - base_r, 1);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule